// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit unsigned or two's complement operands and a carry-in. It is purely combinational. The operands are split into four 4-bit slices. Each slice forms a generate and a propagate for every bit. It derives all of its internal carries in flat AND-OR form from those terms and the slice carry-in, so no carry ripples inside a slice. Each slice also reports a group generate and a group propagate.

A second-level lookahead unit takes the four slice group pairs and the external carry-in. It applies the same flat equations to them to produce the carry into every slice and the final carry-out, so no carry ripples between slices either.

The unit's own group generate and group propagate are brought out as ports. A third level of lookahead can therefore combine several of these adders. There is no data stream and no clock, so the ports are plain wires with no handshake. Every output follows its inputs after the logic delay.

Top module: `cla2_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the 17-bit value `a_i + b_i + cin_i` for every input combination.
- R2: Bit generate is `a & b` and bit propagate is `a ^ b`. Each sum bit is the bit propagate XOR the carry into that bit. Consequently every slice's 4-bit sum plus its carry-out equals its own operands plus its carry-in.
- R3: Every carry inside a slice equals `g(j) | p(j) & c(j)` computed from the carry below it, although the logic forms it without using that carry.
- R4: A slice group generate is 1 exactly when the slice's operands alone (carry-in 0) carry out of the slice. A slice group generate and group propagate are never both 1.
- R5: The carry the second level delivers into slice k+1 equals the carry-out of slice k, for k = 0..2. The carry-out of slice 3 equals `cout_o`.
- R6: `grp_prop_o` is 1 exactly when all 16 bit positions propagate, that is when `a_i ^ b_i` is 16'hFFFF.
- R7: `grp_gen_o` is 1 exactly when `a_i + b_i` with no carry-in reaches 2^16.
- R8: `cout_o` equals `grp_gen_o | (grp_prop_o & cin_i)`.
- R9: For a full propagate chain (for example 16'hFFFF + 16'h0000 with carry-in 1), the result is sum 0 with carry-out 1, and `grp_prop_o` is 1 with `grp_gen_o` 0.
- R10: The block holds no state. The outputs reflect the current inputs with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Group generate of the whole 16-bit adder |
| grp_prop_o | output | 1 | Group propagate of the whole 16-bit adder |

## Verification
The bench drives the inputs where a carry has to cross every level at once. These are all-ones plus one and an all-propagate pattern with the carry-in toggled. A design that broke the chain at a slice edge would leave a stray 1 in the sum and lose the carry-out. Alternating bit patterns and carries generated at the top bit of each slice target a swapped or misindexed group term. Such a design would deliver the carry into the wrong slice, or drop it, and the sum would be off by 16, 256 or 4096. The group outputs are compared against the arithmetic definitions on every vector. A group generate built from propagate, or a missing carry-in term, shows up as a wrong `grp_gen_o` or `cout_o`.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Fan-in of one lookahead level: bits per slice and slices per adder.
  parameter int LA_RADIX = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_pair_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = cla_pkg::LA_RADIX
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [N:0] c_all;
  logic       gg;
  logic       gp;

  // Flat sum-of-products carries: carry j is OR over k<j of
  // (g[k] AND p[k+1..j-1]) plus (p[0..j-1] AND cin).
  always_comb begin
    logic acc;
    logic prod;
    c_all[0] = cin_i;
    for (int j = 1; j <= N; j++) begin
      acc = cin_i;
      for (int m = 0; m < j; m++) acc = acc & prop_i[m];
      for (int k = 0; k < j; k++) begin
        prod = gen_i[k];
        for (int m = k + 1; m < j; m++) prod = prod & prop_i[m];
        acc = acc | prod;
      end
      c_all[j] = acc;
    end
  end

  always_comb begin
    logic prod;
    gg = 1'b0;
    gp = 1'b1;
    for (int k = 0; k < N; k++) begin
      gp   = gp & prop_i[k];
      prod = gen_i[k];
      for (int m = k + 1; m < N; m++) prod = prod & prop_i[m];
      gg = gg | prod;
    end
  end

  assign carry_o    = c_all[N-1:0];
  assign cout_o     = c_all[N];
  assign grp_gen_o  = gg;
  assign grp_prop_o = gp;

  // Flat carries must agree with the recursive form.
  always_comb begin
    if (!$isunknown({gen_i, prop_i, cin_i})) begin
      for (int j = 0; j < N; j++) begin
        p_carry_recur_r3: assert (c_all[j+1] == (gen_i[j] | (prop_i[j] & c_all[j])))
          else $error("carry %0d breaks recursion", j);
      end
      p_cout_from_group_r8: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)))
        else $error("cout disagrees with group terms");
    end
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int W = cla_pkg::LA_RADIX
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-1:0] bit_carry;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i ^ b_i;

  cla_lookahead #(.N(W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (bit_carry),
    .cout_o     (cout_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  assign sum_o = bit_prop ^ bit_carry;

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_slice_sum_r2: assert ({cout_o, sum_o} ==
          ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("slice sum wrong");
      p_slice_ggen_r4: assert (grp_gen_o == (({1'b0, a_i} + {1'b0, b_i}) >> W))
        else $error("slice group generate wrong");
      p_slice_excl_r4: assert (!(grp_gen_o && grp_prop_o))
        else $error("slice generate and propagate both set");
    end
  end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder #(
  parameter  int SLICE_W    = cla_pkg::LA_RADIX,
  parameter  int NUM_SLICES = cla_pkg::LA_RADIX,
  localparam int DATA_W     = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              grp_gen_o,
  output logic              grp_prop_o
);
  cla_pkg::grp_pair_t [NUM_SLICES-1:0] slice_grp;
  logic [NUM_SLICES-1:0] slice_gen;
  logic [NUM_SLICES-1:0] slice_prop;
  logic [NUM_SLICES-1:0] slice_cin;
  logic [NUM_SLICES-1:0] slice_cout;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i        (a_i[s*SLICE_W +: SLICE_W]),
      .b_i        (b_i[s*SLICE_W +: SLICE_W]),
      .cin_i      (slice_cin[s]),
      .sum_o      (sum_o[s*SLICE_W +: SLICE_W]),
      .cout_o     (slice_cout[s]),
      .grp_gen_o  (slice_grp[s].gen),
      .grp_prop_o (slice_grp[s].prop)
    );
    assign slice_gen[s]  = slice_grp[s].gen;
    assign slice_prop[s] = slice_grp[s].prop;
  end

  // Second level: same lookahead equations over slice group pairs.
  cla_lookahead #(.N(NUM_SLICES)) u_group (
    .gen_i      (slice_gen),
    .prop_i     (slice_prop),
    .cin_i      (cin_i),
    .carry_o    (slice_cin),
    .cout_o     (cout_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_total_sum_r1: assert ({cout_o, sum_o} ==
          ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}))
        else $error("adder result wrong");
      for (int s = 0; s < NUM_SLICES - 1; s++) begin
        p_slice_link_r5: assert (slice_cout[s] == slice_cin[s+1])
          else $error("slice %0d carry link broken", s);
      end
      p_last_link_r5: assert (slice_cout[NUM_SLICES-1] == cout_o)
        else $error("last slice carry differs from cout");
      p_top_prop_r6: assert (grp_prop_o == ((a_i ^ b_i) == {DATA_W{1'b1}}))
        else $error("top group propagate wrong");
      p_top_gen_r7: assert (grp_gen_o == (({1'b0, a_i} + {1'b0, b_i}) >> DATA_W))
        else $error("top group generate wrong");
    end
  end
endmodule

// File: tb/cla2_adder_tb.sv
module cla2_adder_tb;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout, ggen, gprop;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cla2_adder u_dut (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .grp_gen_o(ggen), .grp_prop_o(gprop)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, sample one half-period later away from the posedge.
  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input string req);
    logic [16:0] full;
    logic [16:0] nocin;
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk); #1;
    full  = {1'b0, x} + {1'b0, y} + {16'd0, c};
    nocin = {1'b0, x} + {1'b0, y};
    chk({req, "/R1"}, "sum",  {16'd0, sum},  {16'd0, full[15:0]});
    chk({req, "/R1"}, "cout", {31'd0, cout}, {31'd0, full[16]});
    chk({req, "/R6"}, "grp_prop", {31'd0, gprop}, {31'd0, ((x ^ y) == 16'hFFFF)});
    chk({req, "/R7"}, "grp_gen",  {31'd0, ggen},  {31'd0, nocin[16]});
    chk({req, "/R8"}, "cout_vs_group", {31'd0, cout},
        {31'd0, (nocin[16] | (((x ^ y) == 16'hFFFF) & c))});
  endtask

  task automatic t_zero_state;
    apply(16'h0000, 16'h0000, 1'b0, "R1_zero");
  endtask

  // R10: outputs follow inputs with no clock edge.
  task automatic t_no_clock;
    @(negedge clk);
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    #1;
    chk("R10", "sum_async", {16'd0, sum}, 32'h5556);
    a = 16'hFFFF; b = 16'h0001; cin = 1'b0;
    #1;
    chk("R10", "cout_async", {31'd0, cout}, 32'd1);
  endtask

  task automatic t_all_ones_plus_one;
    apply(16'hFFFF, 16'h0001, 1'b0, "R9_ones_plus_b");
    apply(16'hFFFF, 16'h0000, 1'b1, "R9_ones_plus_cin");
    chk("R9", "chain_sum",  {16'd0, sum},   32'd0);
    chk("R9", "chain_cout", {31'd0, cout},  32'd1);
    chk("R9", "chain_prop", {31'd0, gprop}, 32'd1);
    chk("R9", "chain_gen",  {31'd0, ggen},  32'd0);
  endtask

  task automatic t_full_propagate;
    apply(16'hAAAA, 16'h5555, 1'b0, "R6_prop_c0");
    apply(16'hAAAA, 16'h5555, 1'b1, "R6_prop_c1");
    apply(16'h0F0F, 16'hF0F0, 1'b1, "R6_prop_nib");
    apply(16'h7FFF, 16'h8000, 1'b1, "R9_prop_split");
  endtask

  task automatic t_alternating;
    apply(16'hAAAA, 16'hAAAA, 1'b0, "R2_alt_a");
    apply(16'h5555, 16'h5555, 1'b1, "R2_alt_5");
    apply(16'hCCCC, 16'h3333, 1'b0, "R2_alt_cc");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R7_all_gen");
  endtask

  // Carry generated at top bit of each slice must land in the next slice.
  task automatic t_slice_boundaries;
    apply(16'h0008, 16'h0008, 1'b0, "R5_s0");
    apply(16'h0080, 16'h0080, 1'b0, "R5_s1");
    apply(16'h0800, 16'h0800, 1'b0, "R5_s2");
    apply(16'h8000, 16'h8000, 1'b0, "R5_s3");
    apply(16'h000F, 16'h0000, 1'b1, "R3_in_slice");
    apply(16'h00F7, 16'h0009, 1'b0, "R4_slice_gen");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1_rand");
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    t_zero_state();
    t_no_clock();
    t_all_ones_plus_one();
    t_full_propagate();
    t_alternating();
    t_slice_boundaries();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule